// File: doc/BRIEF.md
# Quick-Trip Laser Fault Monitor with Latched Shutdown

This block watches a laser transmitter for three fast fault conditions: optical power too high, optical power too low, and bias drive too high. It also takes a supply-bad flag. It works on digital codes only. The inputs are a measured photodiode current code, the power setpoint code, and the top byte of the bias DAC code. From these the block drives a fault output pin and an output-off signal, which turns off the bias and modulation drive.

Each power alarm has a 3-bit threshold code. The code picks a multiplier of the setpoint. The bias alarm compares its 8-bit threshold directly with the bias byte. A per-alarm shutdown-enable bit decides whether a firing alarm only raises the fault pin or also sets a sticky shutdown latch. A latch is cleared by a falling edge of the disable pin, or by supply-bad, and only once its fault has gone. After the last latch clears, a fixed hold timer keeps the combined shutdown flag high for a further `HOLD_CYCLES` clocks (130 ms at 50 MHz by default).

Top module: `qtrip_shutdown_ctrl`

## Requirements
- R1: On a cycle with `sample_stb` high, `alarm_o[2]` (high power) is set exactly when `hi_thr` is 2..7 and `pd_code*100 > set_code*M`. M is 130, 143, 156, 169, 182 or 195 for codes 2, 3, 4, 5, 6 and 7.
- R2: On a strobe cycle, `alarm_o[1]` (low power) is set exactly when all three of these hold:
  - `lo_thr` is 2..7;
  - `pd_code*100 < set_code*M`, where M is 81, 76, 54, 41, 28 or 14 for codes 2, 3, 4, 5, 6 and 7;
  - none of `tx_dis`, `soft_dis` or `supply_bad` is high.
- R3: On a strobe cycle, `alarm_o[0]` (high bias) is set exactly when `bias_thr != 0` and `bias_msb > bias_thr`.
- R4: Threshold codes 0 and 1 for either power alarm, and a bias threshold of 0, disable that alarm. It never sets its flag, its latch or the fault pin.
- R5: Alarm flags change only on the edge of a cycle with `sample_stb` high. Between strobes they hold their value.
- R6: An alarm flag that is high while its `sd_en` bit is set sets its `sd_latch_o` bit on the next edge. With `sd_en` clear the latch is not set, and `fault_o` is still asserted.
- R7: A set latch clears on an edge where `supply_bad` is high, or where `tx_dis` falls. It clears only if its alarm flag is low. Otherwise it stays set.
- R8: `sd_flag_o` is high while any latch is set. It stays high for exactly `HOLD_CYCLES` further cycles after the last latch clears.
- R9: `fault_o` is high exactly when `supply_bad`, any alarm flag, or `sd_flag_o` is high.
- R10: `drive_off_o` is high exactly when `tx_dis`, `soft_dis`, `supply_bad` or `sd_flag_o` is high.
- R11: After a synchronous reset, all flags, latches and the hold timer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_stb | input | 1 | Alarm evaluation strobe |
| pd_code | input | CODE_W | Measured photodiode current code |
| set_code | input | CODE_W | Photodiode current setpoint code |
| bias_msb | input | 8 | Top byte of the bias DAC code |
| hi_thr | input | 3 | High-power threshold code |
| lo_thr | input | 3 | Low-power threshold code |
| bias_thr | input | 8 | High-bias threshold |
| sd_en | input | 3 | Shutdown enables: [2] high power, [1] low power, [0] bias |
| tx_dis | input | 1 | Transmit disable pin |
| soft_dis | input | 1 | Software disable bit |
| supply_bad | input | 1 | Supply below operating level |
| alarm_o | output | 3 | Alarm flags: [2] high power, [1] low power, [0] bias |
| sd_latch_o | output | 3 | Per-alarm shutdown latches, same bit order |
| sd_flag_o | output | 1 | Combined shutdown flag including the hold time |
| fault_o | output | 1 | Transmit fault output |
| drive_off_o | output | 1 | Forces bias and modulation drive off |

## Verification
The assertions check, on every cycle, these local rules:
- flags never move without a strobe;
- disabled threshold codes never raise a flag;
- a latch sets after an enabled alarm and cannot clear while its alarm is present;
- the combined flag never falls while a latch is set;
- supply-bad always forces the fault pin and the drive off.

Only the bench scenarios can show the rest:
- the exact multiplier boundaries;
- masking of the low-power alarm during disable;
- the falling-edge clear sequence;
- the exact length of the hold window.

// File: rtl/qtrip_pkg.sv
package qtrip_pkg;

    localparam int NUM_ALARMS = 3;
    localparam int IDX_BIAS   = 0;
    localparam int IDX_LO     = 1;
    localparam int IDX_HI     = 2;
    localparam int SCALE      = 100;
    localparam int MULT_W     = 8;

    typedef logic [NUM_ALARMS-1:0] alarm_vec_t;

    typedef enum logic [2:0] {
        THR_OFF  = 3'd0,
        THR_RSVD = 3'd1,
        THR_L2   = 3'd2,
        THR_L3   = 3'd3,
        THR_L4   = 3'd4,
        THR_L5   = 3'd5,
        THR_L6   = 3'd6,
        THR_L7   = 3'd7
    } thr_code_e;

    // Codes 0 and 1 leave the alarm inactive
    function automatic logic code_active(input logic [2:0] code);
        return code >= 3'd2;
    endfunction

    // High-power multiplier of the setpoint, scaled by 100
    function automatic logic [MULT_W-1:0] hi_mult(input logic [2:0] code);
        case (thr_code_e'(code))
            THR_L2:  return 8'd130;
            THR_L3:  return 8'd143;
            THR_L4:  return 8'd156;
            THR_L5:  return 8'd169;
            THR_L6:  return 8'd182;
            THR_L7:  return 8'd195;
            default: return 8'd0;
        endcase
    endfunction

    // Low-power multiplier of the setpoint, scaled by 100
    function automatic logic [MULT_W-1:0] lo_mult(input logic [2:0] code);
        case (thr_code_e'(code))
            THR_L2:  return 8'd81;
            THR_L3:  return 8'd76;
            THR_L4:  return 8'd54;
            THR_L5:  return 8'd41;
            THR_L6:  return 8'd28;
            THR_L7:  return 8'd14;
            default: return 8'd0;
        endcase
    endfunction

endpackage

// File: rtl/qtrip_eval.sv
module qtrip_eval
    import qtrip_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BIAS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_stb,
    input  logic [CODE_W-1:0] pd_code,
    input  logic [CODE_W-1:0] set_code,
    input  logic [BIAS_W-1:0] bias_msb,
    input  logic [2:0]        hi_thr,
    input  logic [2:0]        lo_thr,
    input  logic [BIAS_W-1:0] bias_thr,
    input  logic              lo_mask,
    output alarm_vec_t        alarm_q
);
    localparam int PROD_W = CODE_W + MULT_W;

    logic [PROD_W-1:0] pd_x100;
    logic [PROD_W-1:0] hi_lim;
    logic [PROD_W-1:0] lo_lim;
    alarm_vec_t        hit;

    always_comb begin
        pd_x100 = PROD_W'(pd_code) * PROD_W'(SCALE);
        hi_lim  = PROD_W'(set_code) * PROD_W'(hi_mult(hi_thr));
        lo_lim  = PROD_W'(set_code) * PROD_W'(lo_mult(lo_thr));
        hit[IDX_HI]   = code_active(hi_thr) && (pd_x100 > hi_lim);
        hit[IDX_LO]   = code_active(lo_thr) && !lo_mask && (pd_x100 < lo_lim);
        hit[IDX_BIAS] = (bias_thr != '0) && (bias_msb > bias_thr);
    end

    always_ff @(posedge clk) begin
        if (rst)
            alarm_q <= '0;
        else if (sample_stb)
            alarm_q <= hit;
    end

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_stb |=> $stable(alarm_q));

    // R4
    hi_off_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && hi_thr < 3'd2) |=> !alarm_q[IDX_HI]);

    // R4
    bias_off_chk: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && bias_thr == '0) |=> !alarm_q[IDX_BIAS]);

endmodule

// File: rtl/qtrip_latch.sv
module qtrip_latch (
    input  logic clk,
    input  logic rst,
    input  logic alarm,
    input  logic sd_en,
    input  logic clr_evt,
    output logic latch_q
);
    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= 1'b0;
        else if (alarm && sd_en)
            latch_q <= 1'b1;
        else if (clr_evt && !alarm)
            latch_q <= 1'b0;
    end

    // R6
    latch_set_chk: assert property (@(posedge clk) disable iff (rst)
        (alarm && sd_en) |=> latch_q);

    // R7
    latch_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (latch_q && alarm) |=> latch_q);

endmodule

// File: rtl/qtrip_hold_timer.sv
module qtrip_hold_timer #(
    parameter int HOLD_CYCLES = 6_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic any_latch,
    output logic sd_flag
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (any_latch)
            cnt_q <= CNT_W'(HOLD_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign sd_flag = any_latch || (cnt_q != '0);

endmodule

// File: rtl/qtrip_shutdown_ctrl.sv
module qtrip_shutdown_ctrl
    import qtrip_pkg::*;
#(
    parameter int CODE_W      = 12,
    parameter int HOLD_CYCLES = 6_500_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_stb,
    input  logic [CODE_W-1:0] pd_code,
    input  logic [CODE_W-1:0] set_code,
    input  logic [7:0]        bias_msb,
    input  logic [2:0]        hi_thr,
    input  logic [2:0]        lo_thr,
    input  logic [7:0]        bias_thr,
    input  logic [2:0]        sd_en,
    input  logic              tx_dis,
    input  logic              soft_dis,
    input  logic              supply_bad,
    output logic [2:0]        alarm_o,
    output logic [2:0]        sd_latch_o,
    output logic              sd_flag_o,
    output logic              fault_o,
    output logic              drive_off_o
);
    alarm_vec_t alarm_q;
    alarm_vec_t latch_q;
    logic       prev_dis_q;
    logic       clr_evt;
    logic       lo_mask;

    always_ff @(posedge clk) begin
        if (rst)
            prev_dis_q <= 1'b0;
        else
            prev_dis_q <= tx_dis;
    end

    assign clr_evt = supply_bad || (prev_dis_q && !tx_dis);
    assign lo_mask = tx_dis || soft_dis || supply_bad;

    qtrip_eval #(.CODE_W(CODE_W), .BIAS_W(8)) u_eval (
        .clk        (clk),
        .rst        (rst),
        .sample_stb (sample_stb),
        .pd_code    (pd_code),
        .set_code   (set_code),
        .bias_msb   (bias_msb),
        .hi_thr     (hi_thr),
        .lo_thr     (lo_thr),
        .bias_thr   (bias_thr),
        .lo_mask    (lo_mask),
        .alarm_q    (alarm_q)
    );

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_latch
        qtrip_latch u_latch (
            .clk     (clk),
            .rst     (rst),
            .alarm   (alarm_q[i]),
            .sd_en   (sd_en[i]),
            .clr_evt (clr_evt),
            .latch_q (latch_q[i])
        );
    end

    qtrip_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .any_latch (|latch_q),
        .sd_flag   (sd_flag_o)
    );

    assign alarm_o     = alarm_q;
    assign sd_latch_o  = latch_q;
    assign fault_o     = supply_bad || (|alarm_q) || sd_flag_o;
    assign drive_off_o = tx_dis || soft_dis || supply_bad || sd_flag_o;

    // R8
    flag_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sd_flag_o) |-> (latch_q == '0));

    // R9
    fault_alarm_chk: assert property (@(posedge clk) disable iff (rst)
        (|alarm_q) |-> fault_o);

    // R10
    supply_force_chk: assert property (@(posedge clk) disable iff (rst)
        supply_bad |-> (fault_o && drive_off_o));

endmodule

// File: tb/tb_qtrip_shutdown_ctrl.sv
module tb_qtrip_shutdown_ctrl;
    localparam int CW   = 12;
    localparam int HOLD = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sample_stb = 1'b0;
    logic [CW-1:0] pd_code = '0;
    logic [CW-1:0] set_code = 12'd1000;
    logic [7:0] bias_msb = '0;
    logic [2:0] hi_thr = '0;
    logic [2:0] lo_thr = '0;
    logic [7:0] bias_thr = '0;
    logic [2:0] sd_en = '0;
    logic tx_dis = 1'b0;
    logic soft_dis = 1'b0;
    logic supply_bad = 1'b0;
    logic [2:0] alarm_o;
    logic [2:0] sd_latch_o;
    logic sd_flag_o;
    logic fault_o;
    logic drive_off_o;

    always #10 clk = ~clk;

    qtrip_shutdown_ctrl #(.CODE_W(CW), .HOLD_CYCLES(HOLD)) dut (
        .clk(clk), .rst(rst), .sample_stb(sample_stb),
        .pd_code(pd_code), .set_code(set_code), .bias_msb(bias_msb),
        .hi_thr(hi_thr), .lo_thr(lo_thr), .bias_thr(bias_thr),
        .sd_en(sd_en), .tx_dis(tx_dis), .soft_dis(soft_dis),
        .supply_bad(supply_bad), .alarm_o(alarm_o), .sd_latch_o(sd_latch_o),
        .sd_flag_o(sd_flag_o), .fault_o(fault_o), .drive_off_o(drive_off_o)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;
    string cur_req = "R11";

    // behavioural reference state
    int m_al[3];
    int m_la[3];
    int m_cnt = 0;
    int m_prev = 0;

    function automatic int hi_m(int c);
        int t[8] = '{0, 0, 130, 143, 156, 169, 182, 195};
        return t[c];
    endfunction

    function automatic int lo_m(int c);
        int t[8] = '{0, 0, 81, 76, 54, 41, 28, 14};
        return t[c];
    endfunction

    function automatic int m_sd();
        return (m_la[0] | m_la[1] | m_la[2] | (m_cnt > 0)) ? 1 : 0;
    endfunction

    task automatic model_edge();
        int nal[3];
        int any_old;
        int clr;
        any_old = m_la[0] | m_la[1] | m_la[2];
        clr = (supply_bad || (m_prev == 1 && !tx_dis)) ? 1 : 0;
        nal = m_al;
        if (rst) begin
            m_al = '{0, 0, 0};
            m_la = '{0, 0, 0};
            m_cnt = 0;
            m_prev = 0;
            return;
        end
        if (sample_stb) begin
            nal[2] = (hi_thr >= 2 && int'(pd_code) * 100 > int'(set_code) * hi_m(hi_thr)) ? 1 : 0;
            nal[1] = (lo_thr >= 2 && !(tx_dis || soft_dis || supply_bad)
                      && int'(pd_code) * 100 < int'(set_code) * lo_m(lo_thr)) ? 1 : 0;
            nal[0] = (bias_thr != 0 && bias_msb > bias_thr) ? 1 : 0;
        end
        for (int i = 0; i < 3; i++) begin
            if (m_al[i] == 1 && sd_en[i]) m_la[i] = 1;
            else if (clr == 1 && m_al[i] == 0) m_la[i] = 0;
        end
        if (any_old == 1) m_cnt = HOLD;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        m_prev = tx_dis ? 1 : 0;
        m_al = nal;
    endtask

    task automatic compare();
        logic [2:0] e_al;
        logic [2:0] e_la;
        logic e_sd;
        logic e_f;
        logic e_off;
        e_al = {m_al[2][0], m_al[1][0], m_al[0][0]};
        e_la = {m_la[2][0], m_la[1][0], m_la[0][0]};
        e_sd = m_sd()[0];
        e_f = supply_bad || (e_al != 0) || e_sd;
        e_off = tx_dis || soft_dis || supply_bad || e_sd;
        total++;
        if (alarm_o !== e_al || sd_latch_o !== e_la || sd_flag_o !== e_sd
            || fault_o !== e_f || drive_off_o !== e_off) begin
            bad++;
            $display("FAIL %s: actual al=%b la=%b sd=%b f=%b off=%b expected al=%b la=%b sd=%b f=%b off=%b",
                     cur_req, alarm_o, sd_latch_o, sd_flag_o, fault_o, drive_off_o,
                     e_al, e_la, e_sd, e_f, e_off);
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic strobe();
        sample_stb = 1'b1;
        step();
        sample_stb = 1'b0;
    endtask

    task automatic chk(logic act, logic exp, string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int hold_seen;
        @(negedge clk);
        step();
        step();
        rst = 1'b0;
        step();
        // R11 reset state
        chk(alarm_o == 0 && sd_latch_o == 0 && !sd_flag_o && !fault_o, 1'b1, "R11 reset");

        // R1 high-power boundary at 1.30 with setpoint 1000
        cur_req = "R1";
        hi_thr = 3'd2; pd_code = 12'd1300;
        strobe();
        chk(alarm_o[2], 1'b0, "R1 pd=1300 at 1.30");
        pd_code = 12'd1301;
        strobe();
        chk(alarm_o[2], 1'b1, "R1 pd=1301 at 1.30");
        hi_thr = 3'd7; pd_code = 12'd1951;
        strobe();
        chk(alarm_o[2], 1'b1, "R1 pd=1951 at 1.95");
        // R6 no shutdown enable: fault, no latch
        cur_req = "R6";
        step();
        chk(fault_o, 1'b1, "R6 fault without enable");
        chk(sd_latch_o[2], 1'b0, "R6 no latch without enable");

        // R5 no change without strobe
        cur_req = "R5";
        pd_code = 12'd1000;
        step(); step();
        chk(alarm_o[2], 1'b1, "R5 flag holds between strobes");
        strobe();
        chk(alarm_o[2], 1'b0, "R5 flag updates on strobe");

        // R4 disabled codes
        cur_req = "R4";
        pd_code = 12'd4000; hi_thr = 3'd1; sd_en = 3'b111;
        strobe(); step();
        chk(alarm_o[2] || fault_o || sd_latch_o[2], 1'b0, "R4 code 1 inert");
        hi_thr = 3'd0;
        strobe(); step();
        chk(alarm_o[2] || fault_o, 1'b0, "R4 code 0 inert");
        sd_en = 3'b000;

        // R2 low-power boundary at 0.14 and masking
        cur_req = "R2";
        lo_thr = 3'd7; pd_code = 12'd140;
        strobe();
        chk(alarm_o[1], 1'b0, "R2 pd=140 at 0.14");
        pd_code = 12'd139;
        strobe();
        chk(alarm_o[1], 1'b1, "R2 pd=139 at 0.14");
        tx_dis = 1'b1;
        strobe();
        chk(alarm_o[1], 1'b0, "R2 masked by disable pin");
        tx_dis = 1'b0; soft_dis = 1'b1;
        strobe();
        chk(alarm_o[1], 1'b0, "R2 masked by soft disable");
        chk(drive_off_o, 1'b1, "R10 soft disable drives off");
        soft_dis = 1'b0; lo_thr = 3'd0;
        strobe();
        chk(alarm_o[1], 1'b0, "R4 low code 0 inert");

        // R3 bias comparison
        cur_req = "R3";
        pd_code = 12'd1000; bias_thr = 8'd50; bias_msb = 8'd50;
        strobe();
        chk(alarm_o[0], 1'b0, "R3 bias equal to threshold");
        bias_msb = 8'd51;
        strobe();
        chk(alarm_o[0], 1'b1, "R3 bias above threshold");
        bias_thr = 8'd0; bias_msb = 8'd255;
        strobe();
        chk(alarm_o[0] || fault_o, 1'b0, "R4 bias threshold 0 inert");
        bias_msb = 8'd0;

        // R6 latch with enable, R7 sticky while fault present
        cur_req = "R6";
        hi_thr = 3'd2; sd_en = 3'b100; pd_code = 12'd1500;
        strobe();
        step();
        chk(sd_latch_o[2], 1'b1, "R6 latch set");
        chk(sd_flag_o && drive_off_o, 1'b1, "R10 shutdown drives off");
        cur_req = "R7";
        tx_dis = 1'b1; step(); tx_dis = 1'b0; step();
        chk(sd_latch_o[2], 1'b1, "R7 latch kept while fault present");

        // R7 clear on falling edge after fault gone, R8 hold window
        pd_code = 12'd1000;
        strobe();
        chk(sd_latch_o[2], 1'b1, "R7 no clear without event");
        tx_dis = 1'b1; step(); tx_dis = 1'b0; step();
        chk(sd_latch_o[2], 1'b0, "R7 latch cleared on falling edge");
        cur_req = "R8";
        hold_seen = 0;
        while (sd_flag_o && hold_seen < 100) begin
            hold_seen++;
            step();
        end
        chk(hold_seen == HOLD, 1'b1, "R8 hold length");
        chk(fault_o, 1'b0, "R9 fault released after hold");

        // R7 supply-bad clear, R9/R10 supply-bad forcing
        cur_req = "R7";
        pd_code = 12'd1500;
        strobe(); step();
        pd_code = 12'd1000;
        strobe();
        supply_bad = 1'b1;
        step();
        chk(sd_latch_o[2], 1'b0, "R7 supply-bad clears latch");
        chk(fault_o && drive_off_o, 1'b1, "R9 supply-bad forces fault");
        supply_bad = 1'b0;
        cur_req = "R8";
        repeat (HOLD + 3) step();
        chk(sd_flag_o, 1'b0, "R8 flag dropped");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule